// File: doc/BRIEF.md
# Split Pending-Transaction Buffer

This block keeps the in-flight state of coherence transactions for a protocol engine. It has two halves. The address half holds, for each entry, a line address and a valid bit, and is searched in one pass by incoming requests. The content half holds one state word per entry. It has two read ports and two write ports, so the request stream and the response stream can each read and write it in the same cycle.

An incoming request searches the address half for a live entry with the same line address. A match is a collision: the request gets that entry's index and its current content. With no match, the request takes the lowest-numbered free entry. The block writes the request's initial state into it and returns the new index. Downstream traffic carries this index. If no entry is free, the request is reported as full and nothing changes. An incoming response names an entry by index. It reads that entry's content, may overwrite it, and may retire the entry, which frees it for reuse.

Both input streams use valid/ready. Each ready is low during reset and high in every cycle after it. Every accepted beat is therefore taken at the clock edge where its valid is high. Each accepted beat produces exactly one result beat on the next cycle. The result streams carry only a valid and cannot be back-pressured.

Top module: `pb_top`

## Requirements
- R1: While rst_n is low, req_ready, rsp_ready, res_valid and rsp_out_valid are 0. After reset, every entry is empty.
- R2: A request whose address matches no live entry, with at least one free entry, takes the lowest-numbered free entry. In the next cycle it reports res_valid=1, res_hit=0, res_full=0, res_idx set to that entry and res_data equal to the request's req_state. The entry then holds that address and state.
- R3: A request whose address matches a live entry reports, in the next cycle, res_hit=1, res_full=0, res_idx set to that entry and res_data equal to its content. Nothing is allocated.
- R4: A request that matches no live entry while all entries are live reports res_full=1, res_hit=0, res_idx=0 and res_data=0 in the next cycle. Nothing is allocated.
- R5: An accepted response produces rsp_out_valid=1 in the next cycle. rsp_out_data equals the entry's content before any write made in the response's own cycle.
- R6: A response with rsp_upd=1 replaces the entry's content with rsp_data.
- R7: A response with rsp_final=1 frees its entry. A request in the same cycle does not match that entry. The freed entry can be allocated only from the following cycle on.
- R8: An allocation and a freeing response in the same cycle both take effect.
- R9: If a request collides with the entry that a response updates in the same cycle, res_data returns the newly written rsp_data.
- R10: After reset, req_ready and rsp_ready stay 1. res_valid and rsp_out_valid are 1 only in the cycle after an accepted beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Request stream can accept |
| req_addr | input | ADDR_W | Line address of the request |
| req_state | input | STATE_W | Initial state written on allocation |
| res_valid | output | 1 | Request result beat |
| res_hit | output | 1 | Collision with a live entry |
| res_full | output | 1 | No free entry; nothing allocated |
| res_idx | output | IDX_W | Collided or allocated entry index |
| res_data | output | STATE_W | Content of the collided entry or the new state |
| rsp_valid | input | 1 | Response beat present |
| rsp_ready | output | 1 | Response stream can accept |
| rsp_idx | input | IDX_W | Entry the response refers to |
| rsp_upd | input | 1 | Overwrite the entry's content |
| rsp_data | input | STATE_W | New content when rsp_upd is set |
| rsp_final | input | 1 | Free the entry |
| rsp_out_valid | output | 1 | Response read result beat |
| rsp_out_data | output | STATE_W | Entry content read by the response |

## Verification
Every result is due exactly one cycle after the edge that accepts its beat. At that edge the block updates its entries and registers both result streams together. The bench's behavioural model uses the entry state from before the edge to predict what the design registers at that edge, and then applies the same updates. Inputs change on the falling edge and outputs are compared on the following falling edge, so each result is read in the one cycle it is due. Same-cycle cases are tested on purpose: a collision with an entry being updated, a request to an entry being freed, and allocation alongside freeing.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [1:0] {
    RK_ALLOC = 2'd0,
    RK_HIT   = 2'd1,
    RK_FULL  = 2'd2
  } res_kind_e;
endpackage

// File: rtl/pb_lowest.sv
module pb_lowest #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/pb_cam.sv
module pb_cam #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] srch_addr,
  input  logic              drop_en,
  input  logic [IDX_W-1:0]  drop_idx,
  input  logic              alloc_en,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic              any_free,
  output logic [IDX_W-1:0]  free_idx
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  match;
  logic [DEPTH-1:0]  empty;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign match[g] = vld_q[g] && (addr_q[g] == srch_addr) &&
                      !(drop_en && (drop_idx == IDX_W'(g)));
    assign empty[g] = !vld_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
      end else if (alloc_en && (alloc_idx == IDX_W'(g))) begin
        vld_q[g] <= 1'b1;
      end else if (drop_en && (drop_idx == IDX_W'(g))) begin
        vld_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc_en && (alloc_idx == IDX_W'(g))) begin
        addr_q[g] <= alloc_addr;
      end
    end
  end

  pb_lowest #(.N(DEPTH)) u_hit_enc (
    .vec   (match),
    .found (hit),
    .idx   (hit_idx)
  );

  pb_lowest #(.N(DEPTH)) u_free_enc (
    .vec   (empty),
    .found (any_free),
    .idx   (free_idx)
  );
endmodule

// File: rtl/pb_content.sv
module pb_content #(
  parameter int DEPTH   = 8,
  parameter int STATE_W = 12,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               qwr_en,
  input  logic [IDX_W-1:0]   qwr_idx,
  input  logic [STATE_W-1:0] qwr_data,
  input  logic [IDX_W-1:0]   qrd_idx,
  output logic [STATE_W-1:0] qrd_data,
  input  logic               swr_en,
  input  logic [IDX_W-1:0]   swr_idx,
  input  logic [STATE_W-1:0] swr_data,
  input  logic [IDX_W-1:0]   srd_idx,
  output logic [STATE_W-1:0] srd_data
);
  logic [STATE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (swr_en) mem[swr_idx] <= swr_data;
    if (qwr_en) mem[qwr_idx] <= qwr_data;
  end

  // request-side read forwards a same-cycle response write
  assign qrd_data = (swr_en && (swr_idx == qrd_idx)) ? swr_data : mem[qrd_idx];
  // response-side read returns the pre-edge content
  assign srd_data = mem[srd_idx];
endmodule

// File: rtl/pb_top.sv
module pb_top
  import pb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DEPTH   = 8,
  parameter int STATE_W = 12,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [STATE_W-1:0] req_state,
  output logic               res_valid,
  output logic               res_hit,
  output logic               res_full,
  output logic [IDX_W-1:0]   res_idx,
  output logic [STATE_W-1:0] res_data,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [IDX_W-1:0]   rsp_idx,
  input  logic               rsp_upd,
  input  logic [STATE_W-1:0] rsp_data,
  input  logic               rsp_final,
  output logic               rsp_out_valid,
  output logic [STATE_W-1:0] rsp_out_data
);
  logic               ready_q;
  logic               req_acc, rsp_acc;
  logic               hit, any_free;
  logic [IDX_W-1:0]   hit_idx, free_idx;
  logic               alloc_en;
  logic [STATE_W-1:0] q_rd_data, s_rd_data;
  res_kind_e          kind;

  assign req_acc  = req_valid && ready_q;
  assign rsp_acc  = rsp_valid && ready_q;
  assign alloc_en = req_acc && !hit && any_free;

  always_comb begin
    if (hit)           kind = RK_HIT;
    else if (any_free) kind = RK_ALLOC;
    else               kind = RK_FULL;
  end

  pb_cam #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_cam (
    .clk        (clk),
    .rst_n      (rst_n),
    .srch_addr  (req_addr),
    .drop_en    (rsp_acc && rsp_final),
    .drop_idx   (rsp_idx),
    .alloc_en   (alloc_en),
    .alloc_idx  (free_idx),
    .alloc_addr (req_addr),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .any_free   (any_free),
    .free_idx   (free_idx)
  );

  pb_content #(.DEPTH(DEPTH), .STATE_W(STATE_W)) u_content (
    .clk      (clk),
    .qwr_en   (alloc_en),
    .qwr_idx  (free_idx),
    .qwr_data (req_state),
    .qrd_idx  (hit_idx),
    .qrd_data (q_rd_data),
    .swr_en   (rsp_acc && rsp_upd),
    .swr_idx  (rsp_idx),
    .swr_data (rsp_data),
    .srd_idx  (rsp_idx),
    .srd_data (s_rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q       <= 1'b0;
      res_valid     <= 1'b0;
      res_hit       <= 1'b0;
      res_full      <= 1'b0;
      res_idx       <= '0;
      res_data      <= '0;
      rsp_out_valid <= 1'b0;
      rsp_out_data  <= '0;
    end else begin
      ready_q       <= 1'b1;
      res_valid     <= req_acc;
      rsp_out_valid <= rsp_acc;
      if (req_acc) begin
        res_hit  <= (kind == RK_HIT);
        res_full <= (kind == RK_FULL);
        unique case (kind)
          RK_HIT:   begin res_idx <= hit_idx;  res_data <= q_rd_data; end
          RK_ALLOC: begin res_idx <= free_idx; res_data <= req_state; end
          default:  begin res_idx <= '0;       res_data <= '0;        end
        endcase
      end
      if (rsp_acc) rsp_out_data <= s_rd_data;
    end
  end

  assign req_ready = ready_q;
  assign rsp_ready = ready_q;
endmodule

// File: rtl/pb_check.sv
module pb_check #(
  parameter int IDX_W   = 3,
  parameter int STATE_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [STATE_W-1:0] req_state,
  input logic               res_valid,
  input logic               res_hit,
  input logic               res_full,
  input logic [IDX_W-1:0]   res_idx,
  input logic [STATE_W-1:0] res_data,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_out_valid
);
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!res_valid && !rsp_out_valid && !req_ready && !rsp_ready);
    end
  end

  assert_result_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  assert_no_stray_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !res_valid);

  assert_ready_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (req_ready && rsp_ready));

  assert_alloc_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit && !res_full) |-> (res_data == $past(req_state)));

  assert_hit_full_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_hit && res_full));

  assert_full_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_full) |-> (res_idx == '0 && res_data == '0));

  assert_rsp_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> rsp_out_valid);

  assert_rsp_no_stray_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_ready) |=> !rsp_out_valid);
endmodule

bind pb_top pb_check #(.IDX_W(IDX_W), .STATE_W(STATE_W)) u_chk (.*);

// File: tb/pb_top_test.sv
module pb_top_test;
  localparam int AW = 16, D = 8, SW = 12, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, rsp_valid = 0, rsp_upd = 0, rsp_final = 0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_state = '0, rsp_data = '0;
  logic [IW-1:0] rsp_idx = '0;
  logic req_ready, rsp_ready, res_valid, res_hit, res_full, rsp_out_valid;
  logic [IW-1:0] res_idx;
  logic [SW-1:0] res_data, rsp_out_data;

  always #2 clk = ~clk;

  pb_top #(.ADDR_W(AW), .DEPTH(D), .STATE_W(SW)) uut (.*);

  int checks = 0, errors = 0;
  int m_addr [D];
  int m_data [D];
  bit m_vld [D];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit rv, input int ra, input int rs,
                       input bit pv, input int pi, input bit pu, input int pd, input bit pf);
    req_valid = rv; req_addr = AW'(ra); req_state = SW'(rs);
    rsp_valid = pv; rsp_idx = IW'(pi); rsp_upd = pu; rsp_data = SW'(pd); rsp_final = pf;
  endtask

  // one clock: predict from pre-edge model, update model, compare after edge
  task automatic cycle();
    int hit_i, free_i, e_idx, e_data, e_out;
    bit e_hit, e_full;
    string tag;
    hit_i = -1; free_i = -1; tag = "R2";
    for (int i = 0; i < D; i++) begin
      if (hit_i < 0 && m_vld[i] && m_addr[i] == int'(req_addr) &&
          !(rsp_valid && rsp_final && int'(rsp_idx) == i)) hit_i = i;
      if (free_i < 0 && !m_vld[i]) free_i = i;
    end
    e_hit = 0; e_full = 0; e_idx = 0; e_data = 0;
    if (hit_i >= 0) begin
      e_hit = 1; e_idx = hit_i; tag = "R3";
      if (rsp_valid && rsp_upd && int'(rsp_idx) == hit_i) begin
        e_data = int'(rsp_data); tag = "R9";
      end else e_data = m_data[hit_i];
    end else if (free_i >= 0) begin
      e_idx = free_i; e_data = int'(req_state);
      if (rsp_valid && rsp_final) tag = "R8";
    end else begin
      e_full = 1; tag = "R4";
    end
    if (req_valid && rsp_valid && rsp_final && m_vld[rsp_idx] &&
        m_addr[rsp_idx] == int'(req_addr)) tag = "R7";
    e_out = rsp_valid ? m_data[rsp_idx] : 0;
    // model update
    if (rsp_valid && rsp_upd) m_data[rsp_idx] = int'(rsp_data);
    if (rsp_valid && rsp_final) m_vld[rsp_idx] = 0;
    if (req_valid && !e_hit && !e_full) begin
      m_vld[free_i] = 1; m_addr[free_i] = int'(req_addr); m_data[free_i] = int'(req_state);
    end
    begin
      bit rv, pv;
      rv = req_valid; pv = rsp_valid;
      @(posedge clk); @(negedge clk);
      chk(res_valid == rv, "R10 res_valid", int'(res_valid), int'(rv));
      chk(rsp_out_valid == pv, "R10 rsp_out_valid", int'(rsp_out_valid), int'(pv));
      chk(req_ready && rsp_ready, "R10 ready", int'(req_ready), 1);
      if (rv) begin
        chk(res_hit == e_hit, {tag, " hit"}, int'(res_hit), int'(e_hit));
        chk(res_full == e_full, {tag, " full"}, int'(res_full), int'(e_full));
        chk(int'(res_idx) == e_idx, {tag, " idx"}, int'(res_idx), e_idx);
        chk(int'(res_data) == e_data, {tag, " data"}, int'(res_data), e_data);
      end
      if (pv) chk(int'(rsp_out_data) == e_out, "R5 R6 rsp_out_data", int'(rsp_out_data), e_out);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) begin m_vld[i] = 0; m_addr[i] = 0; m_data[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!res_valid && !rsp_out_valid, "R1 outputs in reset", int'(res_valid), 0);
    chk(!req_ready && !rsp_ready, "R1 ready in reset", int'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: fresh allocations
    drive(1, 16'h100, 11, 0, 0, 0, 0, 0); cycle();
    drive(1, 16'h200, 22, 0, 0, 0, 0, 0); cycle();
    drive(1, 16'h300, 33, 0, 0, 0, 0, 0); cycle();
    // R3: collision returns content
    drive(1, 16'h200, 99, 0, 0, 0, 0, 0); cycle();
    // R6 then R5 read-back
    drive(0, 0, 0, 1, 1, 1, 77, 0); cycle();
    drive(0, 0, 0, 1, 1, 0, 0, 0); cycle();
    // R9: collision with same-cycle update
    drive(1, 16'h100, 5, 1, 0, 1, 55, 0); cycle();
    // R7: request to entry being freed allocates a different entry
    drive(1, 16'h300, 44, 1, 2, 0, 0, 1); cycle();
    // fill to full, then R4
    for (int k = 0; k < 6; k++) begin drive(1, 16'h400 + k, 60 + k, 0, 0, 0, 0, 0); cycle(); end
    drive(1, 16'h999, 1, 0, 0, 0, 0, 0); cycle();
    // R8: free and alloc together while full (freed entry not reusable yet -> full)
    drive(1, 16'h998, 2, 1, 4, 0, 0, 1); cycle();
    drive(1, 16'h998, 3, 1, 5, 1, 9, 1); cycle();
    drive(0, 0, 0, 0, 0, 0, 0, 0); cycle();
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int pi;
      bit pv;
      pi = $urandom_range(0, D - 1);
      pv = m_vld[pi] && ($urandom_range(0, 1) == 1);
      drive($urandom_range(0, 2) != 0, $urandom_range(0, 11), $urandom_range(0, 4095),
            pv, pi, $urandom_range(0, 1) == 1, $urandom_range(0, 4095),
            $urandom_range(0, 2) == 0);
      cycle();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule